// File: doc/BRIEF.md
# Byte-Wide Flash Command Interface Model

This block is a behavioural, synthesizable model of the command logic inside a byte-wide flash memory. Bus writes are not stored directly. Each write is decoded as a command byte, or as the operand of a command. A mode register, driven by those writes, decides what a bus read returns: a byte of the internal array, the status byte, or an identifier byte.

Programming a byte and erasing a block are timed operations. Their durations are parameterised cycle counts, scaled down from real device times. An erase can be suspended and later resumed. A program can only clear bits. An erase sets every byte of the addressed block back to FFh. The block is chosen by a fixed map over the upper address bits:

- the lower half of the address space is one main block;
- the next quarter is a parameter block;
- the next eighth is a second parameter block;
- the top eighth is a boot block.

Reads are registered. Assert `bus_re` for one clock, and `bus_rdata` carries the answer in the following cycle.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, or when reset arrives in the middle of an operation, the mode is read-array and the status byte reads 80h.
- R2: Command FFh selects array reads, 70h selects status reads and 90h selects identifier reads. In identifier mode, address bit 0 = 0 returns ID_MFR (A5h by default) and bit 0 = 1 returns ID_DEV (3Ch by default).
- R3: Command 40h followed by one write of address and data starts a program. Status bit 7 reads 0 for PROG_CYC cycles, then reads 1, and reads keep returning status afterwards.
- R4: A program stores the old byte AND the written data, so bits only go from 1 to 0.
- R5: Programming FFh leaves the byte unchanged and ends in status mode with status 80h (no error bit).
- R6: Writing FFh in status mode returns the block to array reads.
- R7: Command 20h followed by D0h erases the block that contains the address of the D0h write: main block = address MSB 0, first parameter block = top bits 10, second parameter block = 110, boot block = 111. Every byte of that block becomes FFh, and bytes outside it are unchanged.
- R8: An erase of the main block keeps bit 7 low for ERASE_MAIN_CYC cycles (default 300). A boot or parameter block erase takes ERASE_SMALL_CYC cycles (default 150).
- R9: In erase setup, any byte other than D0h aborts the erase. It sets status bit 5 (status reads A0h) and leaves the array unchanged.
- R10: B0h during an erase suspends it. Status bit 7 reads 1 and bit 6 reads 1 (C0h), and the erase makes no progress. D0h resumes it, and the erase completes after the remaining cycles.
- R11: Status bits 5 and 6 stay set until command 50h clears them. After 50h, an error mode moves to status mode.
- R12: Writes during a program operation are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 8 | Command or program data byte |
| bus_re | input | 1 | Bus read strobe |
| bus_rdata | output | 8 | Read answer, valid the cycle after bus_re |

## Verification
A wrong mode shows at the very next read. Array data appears where status was expected, or the reverse, and this makes mode tracking directly observable one cycle after any command. A wrong timer load or a timer that is not paused shows as bit 7 flipping too early or too late. The bench probes erase at a point after the short duration but before the long one, and probes a suspended erase long after it would otherwise have finished. Faults in the erase sweep or in program masking stay hidden until the affected byte is read back in array mode, so each operation is followed by reads inside the block, outside it, and at its edges.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    M_RD_ARRAY,
    M_RD_STATUS,
    M_RD_ID,
    M_PROG_SETUP,
    M_PROG_BUSY,
    M_ERASE_SETUP,
    M_ERASE_BUSY,
    M_ERASE_SUSP,
    M_ERASE_ERR
  } mode_e;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_READ_ID     = 8'h90;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
  localparam logic [7:0] CMD_CLEAR_STAT  = 8'h50;

  localparam int STAT_READY_BIT = 7;
  localparam int STAT_SUSP_BIT  = 6;
  localparam int STAT_ERR_BIT   = 5;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // Erased state at power-up; single port with registered read.
  logic [DATA_W-1:0] mem [DEPTH] = '{default: {DATA_W{1'b1}}};

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/flash_block_map.sv
module flash_block_map #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] last,
  output logic              is_main
);
  always_comb begin
    if (!addr[ADDR_W-1]) begin
      base    = '0;
      last    = {1'b0, {(ADDR_W-1){1'b1}}};
      is_main = 1'b1;
    end else if (!addr[ADDR_W-2]) begin
      base    = {2'b10, {(ADDR_W-2){1'b0}}};
      last    = {2'b10, {(ADDR_W-2){1'b1}}};
      is_main = 1'b0;
    end else if (!addr[ADDR_W-3]) begin
      base    = {3'b110, {(ADDR_W-3){1'b0}}};
      last    = {3'b110, {(ADDR_W-3){1'b1}}};
      is_main = 1'b0;
    end else begin
      base    = {3'b111, {(ADDR_W-3){1'b0}}};
      last    = {3'b111, {(ADDR_W-3){1'b1}}};
      is_main = 1'b0;
    end
  end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Paused counter (run low) never finishes.
  assign done = run && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W          = 8,
  parameter int          PROG_CYC        = 12,
  parameter int          ERASE_SMALL_CYC = 150,
  parameter int          ERASE_MAIN_CYC  = 300,
  parameter logic [7:0]  ID_MFR          = 8'hA5,
  parameter logic [7:0]  ID_DEV          = 8'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata
);
  localparam int MAX_CYC = (ERASE_MAIN_CYC > ERASE_SMALL_CYC) ?
                           ((ERASE_MAIN_CYC > PROG_CYC) ? ERASE_MAIN_CYC : PROG_CYC) :
                           ((ERASE_SMALL_CYC > PROG_CYC) ? ERASE_SMALL_CYC : PROG_CYC);
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  mode_e             mode_q, mode_d;
  logic              err_q, susp_q;
  logic              set_err, set_susp, clr_stat;
  logic              prog_start, ers_start;
  logic [ADDR_W-1:0] prog_addr_q;
  logic [7:0]        prog_data_q;
  logic [ADDR_W-1:0] ers_ptr_q, ers_last_q;
  logic              sweep_q;
  logic              tmr_load, tmr_run, tmr_done;
  logic [TMR_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] blk_base, blk_last;
  logic              blk_main;
  logic [ADDR_W-1:0] arr_addr;
  logic              arr_we;
  logic [7:0]        arr_wd, arr_q;
  logic              busy;
  logic [7:0]        stat;
  logic              rd_src_q;
  logic [7:0]        info_q;

  flash_block_map #(.ADDR_W(ADDR_W)) map_i (
    .addr    (bus_addr),
    .base    (blk_base),
    .last    (blk_last),
    .is_main (blk_main)
  );

  flash_op_timer #(.CNT_W(TMR_W)) tmr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .done     (tmr_done)
  );

  flash_array #(.ADDR_W(ADDR_W), .DATA_W(8)) arr_i (
    .clk   (clk),
    .addr  (arr_addr),
    .we    (arr_we),
    .wdata (arr_wd),
    .rdata (arr_q)
  );

  assign busy    = (mode_q == M_PROG_BUSY) || (mode_q == M_ERASE_BUSY);
  assign tmr_run = busy;
  assign stat    = {~busy, susp_q, err_q, 5'b0};

  // Command decode and mode sequencing
  always_comb begin
    mode_d     = mode_q;
    tmr_load   = 1'b0;
    tmr_val    = TMR_W'(PROG_CYC);
    set_err    = 1'b0;
    set_susp   = 1'b0;
    clr_stat   = 1'b0;
    prog_start = 1'b0;
    ers_start  = 1'b0;
    case (mode_q)
      M_RD_ARRAY, M_RD_STATUS, M_RD_ID, M_ERASE_ERR: begin
        if (bus_we) begin
          case (bus_wdata)
            CMD_READ_ARRAY:  mode_d = M_RD_ARRAY;
            CMD_READ_STATUS: mode_d = M_RD_STATUS;
            CMD_READ_ID:     mode_d = M_RD_ID;
            CMD_PROG_SETUP:  mode_d = M_PROG_SETUP;
            CMD_ERASE_SETUP: mode_d = M_ERASE_SETUP;
            CMD_CLEAR_STAT: begin
              clr_stat = 1'b1;
              if (mode_q == M_ERASE_ERR) mode_d = M_RD_STATUS;
            end
            default: ;
          endcase
        end
      end
      M_PROG_SETUP: begin
        if (bus_we) begin
          mode_d     = M_PROG_BUSY;
          prog_start = 1'b1;
          tmr_load   = 1'b1;
          tmr_val    = TMR_W'(PROG_CYC);
        end
      end
      M_PROG_BUSY: begin
        if (tmr_done) mode_d = M_RD_STATUS;
      end
      M_ERASE_SETUP: begin
        if (bus_we) begin
          if (bus_wdata == CMD_CONFIRM) begin
            mode_d    = M_ERASE_BUSY;
            ers_start = 1'b1;
            tmr_load  = 1'b1;
            tmr_val   = blk_main ? TMR_W'(ERASE_MAIN_CYC) : TMR_W'(ERASE_SMALL_CYC);
          end else begin
            mode_d  = M_ERASE_ERR;
            set_err = 1'b1;
          end
        end
      end
      M_ERASE_BUSY: begin
        if (tmr_done) begin
          mode_d = M_RD_STATUS;
        end else if (bus_we && bus_wdata == CMD_SUSPEND) begin
          mode_d   = M_ERASE_SUSP;
          set_susp = 1'b1;
        end
      end
      M_ERASE_SUSP: begin
        if (bus_we && bus_wdata == CMD_CONFIRM) mode_d = M_ERASE_BUSY;
      end
      default: mode_d = M_RD_ARRAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_RD_ARRAY;
      err_q  <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (clr_stat) begin
        err_q  <= 1'b0;
        susp_q <= 1'b0;
      end else begin
        if (set_err)  err_q  <= 1'b1;
        if (set_susp) susp_q <= 1'b1;
      end
    end
  end

  // Program operand capture
  always_ff @(posedge clk) begin
    if (rst) begin
      prog_addr_q <= '0;
      prog_data_q <= 8'hFF;
    end else if (prog_start) begin
      prog_addr_q <= bus_addr;
      prog_data_q <= bus_wdata;
    end
  end

  // Erase sweep: one byte per running cycle, frozen while suspended
  always_ff @(posedge clk) begin
    if (rst) begin
      ers_ptr_q  <= '0;
      ers_last_q <= '0;
      sweep_q    <= 1'b0;
    end else if (ers_start) begin
      ers_ptr_q  <= blk_base;
      ers_last_q <= blk_last;
      sweep_q    <= 1'b1;
    end else if (mode_q == M_ERASE_BUSY && sweep_q) begin
      if (ers_ptr_q == ers_last_q) sweep_q <= 1'b0;
      else                         ers_ptr_q <= ers_ptr_q + 1'b1;
    end
  end

  // Array port steering
  always_comb begin
    if (mode_q == M_ERASE_BUSY) begin
      arr_addr = ers_ptr_q;
      arr_we   = sweep_q;
      arr_wd   = 8'hFF;
    end else if (mode_q == M_PROG_BUSY) begin
      arr_addr = prog_addr_q;
      arr_we   = tmr_done;
      arr_wd   = arr_q & prog_data_q;
    end else begin
      arr_addr = bus_addr;
      arr_we   = 1'b0;
      arr_wd   = 8'hFF;
    end
  end

  // Registered read answer
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_src_q <= 1'b0;
      info_q   <= 8'h00;
    end else if (bus_re) begin
      rd_src_q <= (mode_q == M_RD_ARRAY);
      if (mode_q == M_RD_ID) info_q <= bus_addr[0] ? ID_DEV : ID_MFR;
      else                   info_q <= stat;
    end
  end

  assign bus_rdata = rd_src_q ? arr_q : info_q;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input mode_e      mode_q,
  input logic       arr_we,
  input logic       tmr_done
);
  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1
  always @(negedge clk) begin
    if (rst_seen) begin
      reset_mode_chk: assert (mode_q == M_RD_ARRAY);
    end
  end

  // R3
  prog_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_PROG_SETUP && bus_we) |=> mode_q == M_PROG_BUSY);

  // R12
  prog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_PROG_BUSY && !tmr_done) |=> mode_q == M_PROG_BUSY);

  // R9
  bad_confirm_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_ERASE_SETUP && bus_we && bus_wdata != CMD_CONFIRM) |=> mode_q == M_ERASE_ERR);

  // R10
  suspend_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_ERASE_BUSY && !tmr_done && bus_we && bus_wdata == CMD_SUSPEND)
      |=> mode_q == M_ERASE_SUSP);

  // R10
  suspend_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_ERASE_SUSP) |-> !arr_we);

  // R4
  array_write_mode_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (mode_q == M_PROG_BUSY || mode_q == M_ERASE_BUSY));

  // R6
  status_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_RD_STATUS && bus_we && bus_wdata == CMD_READ_ARRAY) |=> mode_q == M_RD_ARRAY);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk chk_i (.*);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [7:0] OW = 8'd1;  // write
  localparam logic [7:0] OR = 8'd2;  // read and compare
  localparam logic [7:0] OD = 8'd3;  // idle cycles in addr field
  localparam int NV = 58;

  // {requirement, op, addr, data, expected}
  localparam logic [39:0] VEC [NV] = '{
    // R1 reset state, R2 mode selection
    {8'd1, OW, 8'h00, 8'hFF, 8'h00}, {8'd1, OR, 8'h10, 8'h00, 8'hFF},
    {8'd2, OW, 8'h00, 8'h90, 8'h00}, {8'd2, OR, 8'h00, 8'h00, 8'hA5},
    {8'd2, OR, 8'h01, 8'h00, 8'h3C}, {8'd2, OW, 8'h00, 8'h70, 8'h00},
    {8'd2, OR, 8'h00, 8'h00, 8'h80},
    // R6 back to array
    {8'd6, OW, 8'h00, 8'hFF, 8'h00}, {8'd6, OR, 8'h33, 8'h00, 8'hFF},
    // R3 program with busy status, R12 ignored write during program
    {8'd3, OW, 8'h00, 8'h40, 8'h00}, {8'd3, OW, 8'h33, 8'h5A, 8'h00},
    {8'd3, OR, 8'h00, 8'h00, 8'h00}, {8'd12, OW, 8'h00, 8'hFF, 8'h00},
    {8'd3, OD, 8'd15, 8'h00, 8'h00}, {8'd12, OR, 8'h00, 8'h00, 8'h80},
    {8'd3, OW, 8'h00, 8'hFF, 8'h00}, {8'd3, OR, 8'h33, 8'h00, 8'h5A},
    // R4 bits only cleared
    {8'd4, OW, 8'h00, 8'h40, 8'h00}, {8'd4, OW, 8'h33, 8'hF0, 8'h00},
    {8'd4, OD, 8'd15, 8'h00, 8'h00}, {8'd4, OW, 8'h00, 8'hFF, 8'h00},
    {8'd4, OR, 8'h33, 8'h00, 8'h50},
    // R5 all-ones program
    {8'd5, OW, 8'h00, 8'h40, 8'h00}, {8'd5, OW, 8'h33, 8'hFF, 8'h00},
    {8'd5, OD, 8'd15, 8'h00, 8'h00}, {8'd5, OR, 8'h00, 8'h00, 8'h80},
    {8'd5, OW, 8'h00, 8'hFF, 8'h00}, {8'd5, OR, 8'h33, 8'h00, 8'h50},
    // R7 seed bytes in three small blocks
    {8'd7, OW, 8'h00, 8'h40, 8'h00}, {8'd7, OW, 8'h90, 8'h12, 8'h00},
    {8'd7, OD, 8'd15, 8'h00, 8'h00}, {8'd7, OW, 8'h00, 8'h40, 8'h00},
    {8'd7, OW, 8'hE5, 8'h34, 8'h00}, {8'd7, OD, 8'd15, 8'h00, 8'h00},
    {8'd7, OW, 8'h00, 8'h40, 8'h00}, {8'd7, OW, 8'hC8, 8'h56, 8'h00},
    {8'd7, OD, 8'd15, 8'h00, 8'h00},
    // R8 parameter block erase: busy at ~143 cycles, done by ~153
    {8'd7, OW, 8'h00, 8'h20, 8'h00}, {8'd7, OW, 8'h85, 8'hD0, 8'h00},
    {8'd8, OR, 8'h00, 8'h00, 8'h00}, {8'd8, OD, 8'd140, 8'h00, 8'h00},
    {8'd8, OR, 8'h00, 8'h00, 8'h00}, {8'd8, OD, 8'd10, 8'h00, 8'h00},
    {8'd8, OR, 8'h00, 8'h00, 8'h80},
    // R7 only the addressed block erased
    {8'd7, OW, 8'h00, 8'hFF, 8'h00}, {8'd7, OR, 8'h90, 8'h00, 8'hFF},
    {8'd7, OR, 8'hC8, 8'h00, 8'h56}, {8'd7, OR, 8'hE5, 8'h00, 8'h34},
    {8'd7, OR, 8'h33, 8'h00, 8'h50},
    // R8 main block erase: still busy after ~201 cycles
    {8'd8, OW, 8'h00, 8'h20, 8'h00}, {8'd8, OW, 8'h10, 8'hD0, 8'h00},
    {8'd8, OD, 8'd200, 8'h00, 8'h00}, {8'd8, OR, 8'h00, 8'h00, 8'h00},
    {8'd8, OD, 8'd110, 8'h00, 8'h00}, {8'd8, OR, 8'h00, 8'h00, 8'h80},
    {8'd7, OW, 8'h00, 8'hFF, 8'h00}, {8'd7, OR, 8'h33, 8'h00, 8'hFF},
    {8'd7, OR, 8'h7F, 8'h00, 8'hFF}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  int         n_chk = 0;
  int         n_bad = 0;
  logic [39:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata)
  );

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input int req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    n_chk++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL R%0d addr %h: got %h expected %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion within %0d cycles", WATCHDOG);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_chk(1, 8'h20, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      case (v[31:24])
        OW:      wr(v[23:16], v[15:8]);
        OR:      rd_chk(int'(v[39:32]), v[23:16], v[7:0]);
        default: idle(int'(v[23:16]));
      endcase
    end

    // R9 bad confirm byte
    wr(8'h00, 8'h20);
    wr(8'h00, 8'h77);
    rd_chk(9, 8'h00, 8'hA0);
    wr(8'h00, 8'hFF);
    rd_chk(9, 8'hC8, 8'h56);
    // R11 error bit sticky until clear
    wr(8'h00, 8'h70);
    rd_chk(11, 8'h00, 8'hA0);
    wr(8'h00, 8'h50);
    rd_chk(11, 8'h00, 8'h80);

    // R10 suspend and resume of a small block erase
    wr(8'h00, 8'h20);
    wr(8'hC0, 8'hD0);
    idle(20);
    wr(8'h00, 8'hB0);
    rd_chk(10, 8'h00, 8'hC0);
    idle(200);
    rd_chk(10, 8'h00, 8'hC0);
    wr(8'h00, 8'hD0);
    rd_chk(10, 8'h00, 8'h40);
    idle(160);
    rd_chk(10, 8'h00, 8'hC0);
    // R11 suspend flag cleared
    wr(8'h00, 8'h50);
    rd_chk(11, 8'h00, 8'h80);
    wr(8'h00, 8'hFF);
    rd_chk(10, 8'hC8, 8'hFF);
    rd_chk(7, 8'hE5, 8'h34);

    // R1 reset in the middle of an erase
    wr(8'h00, 8'h20);
    wr(8'h10, 8'hD0);
    idle(5);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    rd_chk(1, 8'h33, 8'hFF);
    wr(8'h00, 8'h70);
    rd_chk(1, 8'h00, 8'h80);

    summary();
    $finish;
  end
endmodule